// File: doc/BRIEF.md
# Privileged Preemption Interval Timer

This block is a down-counting interval timer that lets supervisor code take control back from a running user program. Supervisor software writes a count. Every cycle in which the tick enable is high, the count drops by one. When the count steps from one to zero, an interrupt becomes pending. The interrupt stays pending until supervisor code acknowledges it or writes a new count. A second, free-running counter counts every tick, so software can derive elapsed time from it.

A current-mode input marks each cycle as either user (1) or supervisor (0). The mode controls three things:
- A count write is applied only in supervisor mode.
- An acknowledge is applied only in supervisor mode.
- The interrupt mask is applied only in supervisor mode.

A count write or an acknowledge that arrives in user mode has no effect on the timer. It raises a one-cycle privilege-violation pulse instead. The count write uses a valid/ready handshake. The ready signal is always high, so the port never applies back-pressure and a write is taken in the cycle its valid is high.

Top module: `preempt_timer`

## Requirements
- R1: After reset, the count is 0, the elapsed-tick counter is 0, `irq` is low and `priv_fault` is low.
- R2: In a cycle with `tick_en` high, no applied write and a nonzero count, the count decreases by one at the next clock edge. With `tick_en` low and no write, the count holds.
- R3: When the count steps from 1 to 0 on a tick, the interrupt becomes pending. The count then holds at 0 and the interrupt stays pending across further ticks.
- R4: A count write with `wr_valid` high and `user_mode` 0 loads `wr_count` at the next edge and clears any pending interrupt. A write takes priority over a tick in the same cycle.
- R5: A supervisor write of 0 leaves the timer idle: the count stays 0 under ticks and no interrupt becomes pending.
- R6: A count write with `user_mode` 1 is not applied (the count keeps following ticks), and `priv_fault` is high for exactly the next cycle.
- R7: `irq_ack` with `user_mode` 0 clears the pending interrupt at the next edge. An acknowledge in user mode is ignored and raises `priv_fault` for the next cycle. If an expiry and an acknowledge fall in the same cycle, the expiry wins and the interrupt stays pending.
- R8: `irq` equals pending AND NOT(`irq_mask` AND supervisor mode). In user mode, `irq` follows the pending state whatever the value of `irq_mask`.
- R9: The elapsed-tick counter increments by one on every cycle with `tick_en` high and wraps modulo 2^TIME_W. Writes, acknowledges and mode have no effect on it.
- R10: `wr_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | Current mode: 1 user, 0 supervisor |
| tick_en | input | 1 | Timer tick for this cycle |
| wr_valid | input | 1 | Count write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_count | input | CNT_W | New count value |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_mask | input | 1 | Interrupt mask (applied in supervisor mode only) |
| count | output | CNT_W | Current count |
| elapsed | output | TIME_W | Free-running tick count |
| irq | output | 1 | Timer interrupt level |
| priv_fault | output | 1 | One-cycle pulse after a user-mode write or acknowledge |

## Verification
The main countdown is run under the following input patterns, each chosen to separate two behaviours:
- Plain ticks down to zero and past it. This separates holding at zero from wrapping below zero.
- Idle cycles between ticks. This separates gated decrement from free-running decrement.
- A write and a tick in the same cycle. This shows which one has priority.
- A write of zero under continued ticks. This separates a timer that stays idle from one that raises a spurious expiry.

Each write, acknowledge and mask pattern is repeated with the mode input in both states. This separates a timer that checks privilege from one that ignores the mode. An expiry that coincides with an acknowledge shows which of the two wins. A long tick run ending at the wrap boundary checks that the elapsed counter wraps correctly and is not disturbed by timer writes.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  // Privilege decision for one cycle of requests.
  typedef struct packed {
    logic load_ok;   // supervisor write, applied
    logic ack_ok;    // supervisor acknowledge, applied
    logic violation; // user-mode write or acknowledge
    logic mask_eff;  // mask honoured only in supervisor mode
  } ptmr_gate_t;

endpackage

// File: rtl/ptmr_privgate.sv
module ptmr_privgate
  import ptmr_pkg::*;
(
  input  logic       user_mode,
  input  logic       wr_valid,
  input  logic       irq_ack,
  input  logic       irq_mask,
  output ptmr_gate_t gate
);

  always_comb begin
    gate.load_ok   = wr_valid & ~user_mode;
    gate.ack_ok    = irq_ack & ~user_mode;
    gate.violation = user_mode & (wr_valid | irq_ack);
    gate.mask_eff  = irq_mask & ~user_mode;
  end

endmodule

// File: rtl/ptmr_down.sv
module ptmr_down #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_ok,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ack_ok,
  output logic [CNT_W-1:0] count_q,
  output logic             pend_q
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             dec;
  logic             expire;
  logic [CNT_W-1:0] count_d;
  logic             pend_d;

  always_comb begin
    dec    = ~load_ok & tick_en & (count_q != ZERO);
    expire = dec & (count_q == ONE);
    if (load_ok)  count_d = load_val;
    else if (dec) count_d = count_q - ONE;
    else          count_d = count_q;
    // expiry beats acknowledge; a write clears the pending state
    pend_d = expire | (pend_q & ~ack_ok & ~load_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= ZERO;
      pend_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/ptmr_elapsed.sv
module ptmr_elapsed #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  output logic [TIME_W-1:0] elapsed_q
);

  localparam logic [TIME_W-1:0] INC = {{(TIME_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)       elapsed_q <= '0;
    else if (tick_en) elapsed_q <= elapsed_q + INC;
  end

endmodule

// File: rtl/preempt_timer.sv
module preempt_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic              tick_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic              irq_ack,
  input  logic              irq_mask,
  output logic [CNT_W-1:0]  count,
  output logic [TIME_W-1:0] elapsed,
  output logic              irq,
  output logic              priv_fault
);

  ptmr_gate_t gate;
  logic       pend_q;
  logic       fault_q;

  assign wr_ready = 1'b1;

  ptmr_privgate u_gate (
    .user_mode (user_mode),
    .wr_valid  (wr_valid),
    .irq_ack   (irq_ack),
    .irq_mask  (irq_mask),
    .gate      (gate)
  );

  ptmr_down #(.CNT_W(CNT_W)) u_down (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_ok  (gate.load_ok),
    .load_val (wr_count),
    .ack_ok   (gate.ack_ok),
    .count_q  (count),
    .pend_q   (pend_q)
  );

  ptmr_elapsed #(.TIME_W(TIME_W)) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .elapsed_q (elapsed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= gate.violation;
  end

  assign priv_fault = fault_q;
  assign irq        = pend_q & ~gate.mask_eff;

endmodule

// File: rtl/preempt_timer_chk.sv
module preempt_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              user_mode,
  input logic              tick_en,
  input logic              wr_valid,
  input logic [CNT_W-1:0]  wr_count,
  input logic              irq_ack,
  input logic [CNT_W-1:0]  count,
  input logic [TIME_W-1:0] elapsed,
  input logic              irq,
  input logic              pend,
  input logic              priv_fault
);

  localparam logic [CNT_W-1:0]  C1 = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [TIME_W-1:0] T1 = {{(TIME_W-1){1'b0}}, 1'b1};

  // R2
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !(wr_valid && !user_mode) && count != '0)
      |=> count == $past(count) - C1);

  // R3
  a_r3_expire_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !(wr_valid && !user_mode) && count == C1) |=> pend);

  // R3
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !(wr_valid && !user_mode)) |=> count == '0);

  // R4
  a_r4_load_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !user_mode) |=> (count == $past(wr_count) && !pend));

  // R6
  a_r6_user_write_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && user_mode) |=> priv_fault);

  // R6
  a_r6_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && user_mode && !tick_en) |=> $stable(count));

  // R7
  a_r7_user_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && user_mode && pend) |=> pend);

  // R8
  a_r8_user_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && pend) |-> irq);

  // R9
  a_r9_elapsed_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> elapsed == $past(elapsed) + T1);

endmodule

bind preempt_timer preempt_timer_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .user_mode  (user_mode),
  .tick_en    (tick_en),
  .wr_valid   (wr_valid),
  .wr_count   (wr_count),
  .irq_ack    (irq_ack),
  .count      (count),
  .elapsed    (elapsed),
  .irq        (irq),
  .pend       (pend_q),
  .priv_fault (priv_fault)
);

// File: tb/preempt_timer_bench.sv
module preempt_timer_bench;

  localparam int CW = 8;
  localparam int TW = 8;
  localparam int NV = 20;

  // vector: user, tick, wr, value[8], ack, mask | exp count[8], exp irq, exp fault
  localparam int VW = 23;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,8'd3,1'b0,1'b0, 8'd3,1'b0,1'b0}, // 0 R4 load 3
    {1'b0,1'b1,1'b0,8'd0,1'b0,1'b0, 8'd2,1'b0,1'b0}, // 1 R2
    {1'b0,1'b1,1'b0,8'd0,1'b0,1'b0, 8'd1,1'b0,1'b0}, // 2 R2
    {1'b0,1'b1,1'b0,8'd0,1'b0,1'b0, 8'd0,1'b1,1'b0}, // 3 R3 expire
    {1'b0,1'b1,1'b0,8'd0,1'b0,1'b0, 8'd0,1'b1,1'b0}, // 4 R3 hold
    {1'b0,1'b0,1'b0,8'd0,1'b0,1'b1, 8'd0,1'b0,1'b0}, // 5 R8 masked sup
    {1'b1,1'b0,1'b0,8'd0,1'b0,1'b1, 8'd0,1'b1,1'b0}, // 6 R8 user unmaskable
    {1'b1,1'b0,1'b0,8'd0,1'b1,1'b0, 8'd0,1'b1,1'b1}, // 7 R7 user ack
    {1'b1,1'b0,1'b0,8'd0,1'b0,1'b0, 8'd0,1'b1,1'b0}, // 8 R6 pulse ends
    {1'b0,1'b0,1'b0,8'd0,1'b1,1'b0, 8'd0,1'b0,1'b0}, // 9 R7 sup ack
    {1'b1,1'b0,1'b1,8'd5,1'b0,1'b0, 8'd0,1'b0,1'b1}, // 10 R6 user write
    {1'b0,1'b1,1'b1,8'd2,1'b0,1'b0, 8'd2,1'b0,1'b0}, // 11 R4 load beats tick
    {1'b0,1'b1,1'b0,8'd0,1'b0,1'b0, 8'd1,1'b0,1'b0}, // 12 R2
    {1'b0,1'b1,1'b1,8'd0,1'b0,1'b0, 8'd0,1'b0,1'b0}, // 13 R5 load 0
    {1'b0,1'b1,1'b0,8'd0,1'b0,1'b0, 8'd0,1'b0,1'b0}, // 14 R5 stays idle
    {1'b0,1'b0,1'b1,8'd1,1'b0,1'b0, 8'd1,1'b0,1'b0}, // 15 R4 load 1
    {1'b0,1'b1,1'b0,8'd0,1'b1,1'b0, 8'd0,1'b1,1'b0}, // 16 R7 expiry beats ack
    {1'b0,1'b0,1'b1,8'd4,1'b0,1'b0, 8'd4,1'b0,1'b0}, // 17 R4 load clears pending
    {1'b1,1'b1,1'b0,8'd0,1'b0,1'b0, 8'd3,1'b0,1'b0}, // 18 R2 ticks in user mode
    {1'b0,1'b0,1'b0,8'd0,1'b0,1'b0, 8'd3,1'b0,1'b0}  // 19 R2 hold
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          user_mode = 1'b0;
  logic          tick_en = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [CW-1:0] wr_count = '0;
  logic          irq_ack = 1'b0;
  logic          irq_mask = 1'b0;
  logic [CW-1:0] count;
  logic [TW-1:0] elapsed;
  logic          irq;
  logic          priv_fault;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  preempt_timer #(.CNT_W(CW), .TIME_W(TW)) u_preempt_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .user_mode  (user_mode),
    .tick_en    (tick_en),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_count   (wr_count),
    .irq_ack    (irq_ack),
    .irq_mask   (irq_mask),
    .count      (count),
    .elapsed    (elapsed),
    .irq        (irq),
    .priv_fault (priv_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    user_mode = 1'b0; tick_en = 1'b0; wr_valid = 1'b0;
    wr_count = '0; irq_ack = 1'b0; irq_mask = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 count", 32'(count), 0);
    check("R1 elapsed", 32'(elapsed), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 fault", 32'(priv_fault), 0);
    check("R10 ready", 32'(wr_ready), 1);

    for (int i = 0; i < NV; i++) begin
      {user_mode, tick_en, wr_valid, wr_count, irq_ack, irq_mask} = VEC[i][22:10];
      @(posedge clk);
      #1;
      check($sformatf("vec%0d count", i), 32'(count), 32'(VEC[i][9:2]));
      check($sformatf("vec%0d irq", i), 32'(irq), 32'(VEC[i][1]));
      check($sformatf("vec%0d fault", i), 32'(priv_fault), 32'(VEC[i][0]));
    end
    idle_inputs();
    // R9: ten ticks were applied by the table
    check("R9 elapsed after table", 32'(elapsed), 10);

    // R9 wrap and independence from writes
    do_reset();
    tick_en = 1'b1;
    for (int k = 0; k < 256; k++) begin
      wr_valid = (k == 100);
      wr_count = 8'd50;
      user_mode = (k > 200);
      @(posedge clk);
      #1;
    end
    idle_inputs();
    check("R9 wrap", 32'(elapsed), 0);
    check("R10 ready", 32'(wr_ready), 1);

    // R6 user write ignored while ticking: count keeps decrementing
    user_mode = 1'b0; wr_valid = 1'b1; wr_count = 8'd10;
    @(posedge clk); #1;
    user_mode = 1'b1; wr_count = 8'd200; tick_en = 1'b1;
    @(posedge clk); #1;
    idle_inputs();
    check("R6 user write ignored", 32'(count), 9);
    check("R6 fault", 32'(priv_fault), 1);
    @(posedge clk); #1;
    check("R6 fault one cycle", 32'(priv_fault), 0);

    // R1 reset clears a pending interrupt
    wr_valid = 1'b1; wr_count = 8'd1;
    @(posedge clk); #1;
    wr_valid = 1'b0; tick_en = 1'b1;
    @(posedge clk); #1;
    idle_inputs();
    check("R3 pending", 32'(irq), 1);
    do_reset();
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 count after reset", 32'(count), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule